// File: doc/BRIEF.md
# Presettable synchronous binary counter

A four-bit up-counter whose every state change is taken on the rising clock edge. A synchronous active-low clear forces the count to zero. A synchronous active-low load copies a parallel data word into the count. Counting needs two separate enables, named P and T, and both must be high. The count wraps from its all-ones value back to zero.

A ripple-carry flag signals that the count is at all ones, and it is qualified by the T enable alone. Several stages can therefore be chained: the carry of one stage drives the T enable of the next, and a shared P enable pauses the whole chain.

A house-level asynchronous active-low reset, released synchronously by the surrounding chip, puts the count at zero. The width is a parameter and defaults to four. The data and count buses are declared with index 0 as the most significant bit, and neighbouring logic decodes them in that order.

Top module: `sync_bin_counter`

## Requirements
- R1: With both enables held high, the count steps through every value and wraps from all ones (15 at the default width) back to 0.
- R2: When `clr_n` is low at a rising edge, the count is 0 after that edge, whatever the other inputs are.
- R3: When `ld_n` is low and `clr_n` is high at a rising edge, the count after that edge equals `din`.
- R4: When `clr_n` and `ld_n` are high and both `en_p` and `en_t` are high at a rising edge, the count goes up by one (modulo 2^W) on that edge.
- R5: `rco` is high exactly when the count is all ones and `en_t` is high. It is combinational from the count and `en_t`, so it is low at all ones whenever `en_t` is low.
- R6: When `clr_n` and `ld_n` are high and either `en_p` or `en_t` is low at a rising edge, the count keeps its value.
- R7: Clear takes priority over load, and load takes priority over counting.
- R8: Index 0 of `din` and of `q` is the most significant bit and index W-1 is the least significant bit. Loading `din` = {1,0,0,0} (index 0 to 3) gives a count of 8.
- R9: While `rst_n` is low the count is 0, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr_n | input | 1 | Synchronous active-low clear |
| ld_n | input | 1 | Synchronous active-low parallel load |
| en_p | input | 1 | Count enable P, gates counting only |
| en_t | input | 1 | Count enable T, gates counting and the carry flag |
| din | input | W (4) | Parallel load data, index 0 is the MSB |
| q | output | W (4) | Current count, index 0 is the MSB |
| rco | output | 1 | Ripple carry: count is all ones and en_t is high |

## Verification
Clear, load, count and hold results are due one rising edge after the control inputs are applied. The bench drives inputs on the falling edge and compares `q` one time unit after the next rising edge. `rco` has no register of its own, so it is checked in that same window against the new count and the `en_t` value still being driven. The asynchronous reset is checked one time unit after `rst_n` falls, with no edge in between.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  // Operation chosen for the coming clock edge, in priority order.
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_CLEAR = 2'd1,
    MODE_LOAD  = 2'd2,
    MODE_COUNT = 2'd3
  } sbc_mode_e;

endpackage

// File: rtl/sbc_mode_decode.sv
module sbc_mode_decode
  import sbc_pkg::*;
(
  input  logic      clr_n,
  input  logic      ld_n,
  input  logic      en_p,
  input  logic      en_t,
  output sbc_mode_e mode
);

  // Fixed priority: clear, then load, then count; anything else holds.
  always_comb begin
    if (!clr_n) begin
      mode = MODE_CLEAR;
    end else if (!ld_n) begin
      mode = MODE_LOAD;
    end else if (en_p && en_t) begin
      mode = MODE_COUNT;
    end else begin
      mode = MODE_HOLD;
    end
  end

endmodule

// File: rtl/sbc_next_state.sv
module sbc_next_state
  import sbc_pkg::*;
#(
  parameter int W = 4
) (
  input  sbc_mode_e      mode,
  input  logic [W-1:0]   load_val,
  input  logic [W-1:0]   cur_val,
  output logic [W-1:0]   nxt_val,
  output logic           upd_en
);

  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    nxt_val = cur_val;
    upd_en  = 1'b1;
    case (mode)
      MODE_CLEAR: nxt_val = '0;
      MODE_LOAD:  nxt_val = load_val;
      MODE_COUNT: nxt_val = cur_val + ONE;
      default:    upd_en  = 1'b0;
    endcase
  end

endmodule

// File: rtl/sbc_carry_gen.sv
module sbc_carry_gen #(
  parameter int W = 4
) (
  input  logic [W-1:0] cur_val,
  input  logic         en_t,
  output logic         carry
);

  logic all_ones;

  assign all_ones = &cur_val;
  assign carry    = all_ones & en_t;

endmodule

// File: rtl/sync_bin_counter.sv
module sync_bin_counter
  import sbc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_n,
  input  logic         ld_n,
  input  logic         en_p,
  input  logic         en_t,
  input  logic [0:W-1] din,
  output logic [0:W-1] q,
  output logic         rco
);

  sbc_mode_e    mode;
  logic [W-1:0] load_val;
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  // Port index 0 is the MSB; packed assignment maps leftmost to leftmost.
  assign load_val = din;
  assign q        = cnt_q;

  sbc_mode_decode u_decode (
    .clr_n (clr_n),
    .ld_n  (ld_n),
    .en_p  (en_p),
    .en_t  (en_t),
    .mode  (mode)
  );

  sbc_next_state #(.W(W)) u_next (
    .mode     (mode),
    .load_val (load_val),
    .cur_val  (cnt_q),
    .nxt_val  (cnt_d),
    .upd_en   (cnt_en)
  );

  sbc_carry_gen #(.W(W)) u_carry (
    .cur_val (cnt_q),
    .en_t    (en_t),
    .carry   (rco)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/sync_bin_counter_chk.sv
module sync_bin_counter_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clr_n,
  input logic         ld_n,
  input logic         en_p,
  input logic         en_t,
  input logic [0:W-1] din,
  input logic [0:W-1] q,
  input logic         rco
);

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (q == '0));

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !ld_n) |=> (q == $past(din)));

  p_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && ld_n && en_p && en_t) |=> (q == W'($past(q) + 1'b1)));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && ld_n && !(en_p && en_t)) |=> $stable(q));

  p_carry_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((&q) && en_t) |-> rco);

  p_carry_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_t || !(&q)) |-> !rco);

  // R1: the all-ones count wraps to zero when counting
  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((&q) && clr_n && ld_n && en_p && en_t) |=> (q == '0));

endmodule

bind sync_bin_counter sync_bin_counter_chk #(.W(W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .clr_n (clr_n),
  .ld_n  (ld_n),
  .en_p  (en_p),
  .en_t  (en_t),
  .din   (din),
  .q     (q),
  .rco   (rco)
);

// File: tb/sync_bin_counter_bench.sv
module sync_bin_counter_bench;

  localparam int W        = 4;
  localparam int CLK_PER  = 10;
  localparam int MAXV     = (1 << W) - 1;

  logic         clk;
  logic         rst_n;
  logic         clr_n;
  logic         ld_n;
  logic         en_p;
  logic         en_t;
  logic [0:W-1] din;
  logic [0:W-1] q;
  logic         rco;

  int total;
  int bad;
  int exp_cnt;

  sync_bin_counter #(.W(W)) u_sync_bin_counter (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_n (clr_n),
    .ld_n  (ld_n),
    .en_p  (en_p),
    .en_t  (en_t),
    .din   (din),
    .q     (q),
    .rco   (rco)
  );

  initial clk = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  function automatic int model_next(bit c_n, bit l_n, bit p, bit t, int d, int cur);
    if (!c_n)        return 0;
    else if (!l_n)   return d;
    else if (p && t) return (cur + 1) & MAXV;
    else             return cur;
  endfunction

  function automatic bit model_carry(int cur, bit t);
    return (cur == MAXV) && t;
  endfunction

  task automatic chk(string tag, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  // Drive on the falling edge, update the model at the rising edge,
  // compare one time unit later.
  task automatic cyc(bit c_n, bit l_n, bit p, bit t, int d, string tag);
    @(negedge clk);
    clr_n = c_n; ld_n = l_n; en_p = p; en_t = t; din = W'(d);
    @(posedge clk);
    exp_cnt = model_next(c_n, l_n, p, t, d, exp_cnt);
    #1;
    chk(tag, int'(q), exp_cnt);
    chk({tag, " R5 carry"}, int'(rco), int'(model_carry(exp_cnt, t)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    total = 0; bad = 0; exp_cnt = 0;
    rst_n = 1'b0; clr_n = 1'b1; ld_n = 1'b1; en_p = 1'b0; en_t = 1'b0; din = '0;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset count", int'(q), 0);
    chk("R9 reset carry", int'(rco), 0);
    @(negedge clk);
    rst_n = 1'b1;

    cyc(1'b1, 1'b0, 1'b0, 1'b0, 6, "R3 load 6");
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 5, "R2 clear");

    // Full wrap: 1..15, then 0
    for (int i = 0; i < MAXV + 1; i++) begin
      cyc(1'b1, 1'b1, 1'b1, 1'b1, 0, (i == MAXV) ? "R1 wrap" : "R4 count");
    end
    chk("R1 wrapped to zero", int'(q), 0);

    cyc(1'b1, 1'b0, 1'b1, 1'b1, 9, "R3 load 9");
    din = '0;
    @(negedge clk);
    clr_n = 1'b1; ld_n = 1'b0; en_p = 1'b0; en_t = 1'b0;
    din[0] = 1'b1;
    @(posedge clk);
    exp_cnt = 8;
    #1;
    chk("R8 index0 msb value", int'(q), 8);
    chk("R8 q[0] set", int'(q[0]), 1);
    chk("R8 q[3] clear", int'(q[3]), 0);

    cyc(1'b1, 1'b0, 1'b0, 1'b1, 15, "R3 load 15");
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 0, "R6 hold t low");
    chk("R5 carry low when t low", int'(rco), 0);
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 0, "R6 hold p low");
    chk("R5 carry high at 15", int'(rco), 1);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 11, "R7 clear over load");
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 13, "R7 load over count");

    for (int i = 0; i < 400; i++) begin
      bit c_n, l_n, p, t;
      int d;
      c_n = ($urandom % 8) != 0;
      l_n = ($urandom % 6) != 0;
      p   = ($urandom % 4) != 0;
      t   = ($urandom % 4) != 0;
      d   = int'($urandom % (MAXV + 1));
      if (!c_n)        cyc(c_n, l_n, p, t, d, "R2 R7 rand clear");
      else if (!l_n)   cyc(c_n, l_n, p, t, d, "R3 rand load");
      else if (p && t) cyc(c_n, l_n, p, t, d, "R4 rand count");
      else             cyc(c_n, l_n, p, t, d, "R6 rand hold");
    end

    cyc(1'b1, 1'b0, 1'b0, 1'b0, 10, "R3 load before reset");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    exp_cnt = 0;
    chk("R9 async reset", int'(q), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule